// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler with Setting Search

This block produces the timing tick that paces an I2C master's clock line, and it chooses its own divider setting from a requested bus rate. The system clock passes through two dividers in series. The first divider is a power of two chosen by a 3-bit exponent field. The second is a linear divide by (M+1), with M taken from a 4-bit field. A pulse leaves the chain at ten times the target SCL rate. The bit engine that follows spends ten ticks on each SCL period.

Software does not write the divider setting directly. It presents a requested rate in hertz and pulses a start strobe. A search engine then steps through every exponent/linear pair, one per clock. For each pair it decides whether the resulting SCL rate stays at or below the request, and it keeps the fastest qualifying pair. The engine compares products, not quotients, so it needs no hardware divider. When the scan ends, the winner is written into the 7-bit setting register and the divider restarts with the new value.

Top module: `i2c_baud_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, the setting output reads 0x44 (M = 8, N = 4), and `done_o` and `tick_o` are low.
- R2: The setting holds N in bits 2:0 and M in bits 6:3. Consecutive ticks are spaced (M+1) * 2^(N+1) clock cycles apart. This gives SCL = CLK_HZ / (10 * (M+1) * 2^(N+1)).
- R3: When the tick spacing is two cycles or more, `tick_o` is high for exactly one cycle.
- R4: A search selects the setting with the highest SCL rate that is at or below the requested rate. A candidate qualifies when CLK_HZ <= request * 10 * (M+1) * 2^(N+1).
- R5: Candidates are visited with N from 0 to 7 in the outer order and M from 0 to 15 in the inner order. When two settings give the same rate, the one visited first is kept. For a request equal to CLK_HZ / 40, this yields 0x08 (N = 0, M = 1) rather than 0x01.
- R6: When no candidate qualifies, the setting keeps the value it had before the search. This covers a request of zero and any request below the slowest rate.
- R7: `done_o` is a one-cycle pulse. It is seen 128 cycles after the cycle that samples an accepted start. The setting changes only in the cycle `done_o` is high.
- R8: The request is captured when the start is accepted. A start strobe during a running search is ignored and produces neither a second result nor a second `done_o`.
- R9: Every search completion restarts the divider. The first tick after `done_o` comes exactly one full tick spacing of the new setting later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a setting search when the engine is idle |
| req_hz_i | input | REQ_W (32) | Requested SCL rate in hertz |
| baud_o | output | M_W+N_W (7) | Current divider setting, M in 6:3 and N in 2:0 |
| tick_o | output | 1 | Pulse at ten times the SCL rate |
| done_o | output | 1 | One-cycle pulse when a search result is applied |

## Verification
The bench builds the block with its default fields (4-bit M, 3-bit N, exponent offset 1) and sets CLK_HZ to 100,000,000 to match its 100 MHz clock. The settings found then span tick spacings from 2 cycles up to the reset value of 288 and beyond. Requests near 5 MHz reach the smallest setting, which is the two-cycle tick boundary. A request of exactly 2.5 MHz hits an exact-equality tie between two settings. Requests below about 2.4 kHz leave every candidate unqualified.

// File: rtl/i2c_baud_pkg.sv
package i2c_baud_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // Clock cycles between ticks for a given linear field, exponent field and offset.
  function automatic int unsigned tick_period(input int unsigned lin_f,
                                              input int unsigned exp_f,
                                              input int unsigned off);
    return (lin_f + 32'd1) << (exp_f + off);
  endfunction

endpackage

// File: rtl/baud_search.sv
module baud_search
  import i2c_baud_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned REQ_W    = 32,
  parameter int unsigned M_W      = 4,
  parameter int unsigned N_W      = 3,
  parameter int unsigned EXP_OFF  = 1,
  parameter int unsigned RST_BAUD = 'h44
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [REQ_W-1:0]     req_i,
  output logic [M_W+N_W-1:0]   baud_o,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 reload_o
);
  localparam int unsigned IDX_W   = M_W + N_W;
  localparam int unsigned MAX_EXP = (1 << N_W) - 1 + EXP_OFF;
  localparam int unsigned DIV_W   = 4 + M_W + 1 + MAX_EXP;
  localparam int unsigned PROD_W  = REQ_W + DIV_W;
  localparam logic [PROD_W-1:0] CLK_K = PROD_W'(CLK_HZ);

  scan_state_e          state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [REQ_W-1:0]     req_q;
  logic [DIV_W-1:0]     best_div_q;
  logic [IDX_W-1:0]     best_code_q;
  logic                 found_q;
  logic [IDX_W-1:0]     baud_q;
  logic                 done_q;

  logic [M_W-1:0]       cand_m;
  logic [N_W-1:0]       cand_n;
  logic [DIV_W-1:0]     cand_lin;
  logic [DIV_W-1:0]     cand_div;
  logic [PROD_W-1:0]    cand_prod;
  logic                 cand_fits;
  logic                 cand_better;
  logic                 last;
  logic                 fin_found;
  logic [IDX_W-1:0]     fin_code;

  // Scan index is {N, M}: N in the outer order, M in the inner order.
  always_comb begin
    cand_m      = idx_q[M_W-1:0];
    cand_n      = idx_q[IDX_W-1:M_W];
    cand_lin    = DIV_W'(cand_m) + DIV_W'(1);
    cand_div    = (cand_lin * DIV_W'(10)) << (32'(cand_n) + EXP_OFF);
    cand_prod   = PROD_W'(req_q) * PROD_W'(cand_div);
    cand_fits   = (CLK_K <= cand_prod);
    cand_better = cand_fits && (!found_q || (cand_div < best_div_q));
    last        = (state_q == SCAN_RUN) && (idx_q == {IDX_W{1'b1}});
    fin_found   = found_q || cand_fits;
    fin_code    = cand_better ? {cand_m, cand_n} : best_code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SCAN_IDLE;
      idx_q       <= '0;
      req_q       <= '0;
      best_div_q  <= '0;
      best_code_q <= '0;
      found_q     <= 1'b0;
      baud_q      <= IDX_W'(RST_BAUD);
      done_q      <= 1'b0;
    end else begin
      done_q <= last;
      if (state_q == SCAN_IDLE) begin
        if (start_i) begin
          state_q <= SCAN_RUN;
          idx_q   <= '0;
          req_q   <= req_i;
          found_q <= 1'b0;
        end
      end else begin
        idx_q   <= idx_q + IDX_W'(1);
        found_q <= fin_found;
        if (cand_better) begin
          best_div_q  <= cand_div;
          best_code_q <= {cand_m, cand_n};
        end
        if (last) begin
          state_q <= SCAN_IDLE;
          if (fin_found) baud_q <= fin_code;
        end
      end
    end
  end

  assign baud_o   = baud_q;
  assign done_o   = done_q;
  assign busy_o   = (state_q == SCAN_RUN);
  assign reload_o = last;
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned M_W     = 4,
  parameter int unsigned N_W     = 3,
  parameter int unsigned EXP_OFF = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart_i,
  input  logic [M_W+N_W-1:0] baud_i,
  output logic               tick_o
);
  localparam int unsigned MAX_EXP = (1 << N_W) - 1 + EXP_OFF;

  logic [M_W-1:0] lin_f;
  logic [N_W-1:0] exp_f;
  logic           wrap1;
  logic [M_W-1:0] cnt2_q;
  logic           tick_q;

  assign lin_f = baud_i[M_W+N_W-1:N_W];
  assign exp_f = baud_i[N_W-1:0];

  // First stage: divide by a power of two.
  generate
    if (MAX_EXP == 0) begin : g_no_pow
      assign wrap1 = 1'b1;
    end else begin : g_pow
      logic [MAX_EXP-1:0] cnt1_q;
      logic [MAX_EXP-1:0] lim1;
      assign lim1  = MAX_EXP'((64'd1 << (32'(exp_f) + EXP_OFF)) - 64'd1);
      assign wrap1 = (cnt1_q == lim1);
      always_ff @(posedge clk) begin
        if (rst || restart_i)  cnt1_q <= '0;
        else if (wrap1)        cnt1_q <= '0;
        else                   cnt1_q <= cnt1_q + MAX_EXP'(1);
      end
    end
  endgenerate

  // Second stage: divide the first-stage pulses by (M+1).
  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt2_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap1 && (cnt2_q == lin_f);
      if (wrap1) cnt2_q <= (cnt2_q == lin_f) ? '0 : cnt2_q + M_W'(1);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned REQ_W    = 32,
  parameter int unsigned M_W      = 4,
  parameter int unsigned N_W      = 3,
  parameter int unsigned EXP_OFF  = 1,
  parameter int unsigned RST_BAUD = 'h44
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [REQ_W-1:0]   req_hz_i,
  output logic [M_W+N_W-1:0] baud_o,
  output logic               tick_o,
  output logic               done_o
);
  logic scan_busy;
  logic scan_reload;

  baud_search #(
    .CLK_HZ(CLK_HZ), .REQ_W(REQ_W), .M_W(M_W), .N_W(N_W),
    .EXP_OFF(EXP_OFF), .RST_BAUD(RST_BAUD)
  ) u_search (
    .clk(clk), .rst(rst), .start_i(start_i), .req_i(req_hz_i),
    .baud_o(baud_o), .done_o(done_o), .busy_o(scan_busy), .reload_o(scan_reload)
  );

  baud_divider #(
    .M_W(M_W), .N_W(N_W), .EXP_OFF(EXP_OFF)
  ) u_div (
    .clk(clk), .rst(rst), .restart_i(scan_reload), .baud_i(baud_o), .tick_o(tick_o)
  );
endmodule

// File: rtl/i2c_baud_gen_chk.sv
module i2c_baud_gen_chk
  import i2c_baud_pkg::*;
#(
  parameter int unsigned M_W     = 4,
  parameter int unsigned N_W     = 3,
  parameter int unsigned EXP_OFF = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               scan_busy,
  input logic [M_W+N_W-1:0] baud_o,
  input logic               tick_o,
  input logic               done_o
);
  localparam int unsigned SCAN_LAT = (1 << (M_W + N_W)) + 1;

  logic [31:0] gap_q;
  logic [31:0] since_start_q;
  int unsigned per;

  assign per = tick_period(32'(baud_o[M_W+N_W-1:N_W]), 32'(baud_o[N_W-1:0]), EXP_OFF);

  always_ff @(posedge clk) begin
    if (rst)                   gap_q <= '0;
    else if (done_o || tick_o) gap_q <= 32'd1;
    else                       gap_q <= gap_q + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                          since_start_q <= '0;
    else if (start_i && !scan_busy)   since_start_q <= 32'd1;
    else if (since_start_q != 32'd0)  since_start_q <= since_start_q + 32'd1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (gap_q == per)); // R2

  AST_TICK_NARROW: assert property (@(posedge clk) disable iff (rst)
    (tick_o && per >= 2) |=> !tick_o); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (since_start_q == SCAN_LAT)); // R7

  AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(baud_o)); // R6

  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !scan_busy); // R8
endmodule

bind i2c_baud_gen i2c_baud_gen_chk #(
  .M_W(M_W), .N_W(N_W), .EXP_OFF(EXP_OFF)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .scan_busy(scan_busy),
  .baud_o(baud_o), .tick_o(tick_o), .done_o(done_o)
);

// File: tb/sim_i2c_baud_gen.sv
`timescale 1ns/1ps
module sim_i2c_baud_gen;
  localparam int unsigned CLK_HZ = 100_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] req_hz_i = '0;
  logic [6:0]  baud_o;
  logic        tick_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  i2c_baud_gen #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .req_hz_i(req_hz_i),
    .baud_o(baud_o), .tick_o(tick_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Best setting by real-valued rate: highest rate not above the request, first kept on ties.
  function automatic int exp_baud(input longint unsigned rq, input int prev);
    real best_f = -1.0;
    int  code   = prev;
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 16; m++) begin
        real f = real'(CLK_HZ) / (10.0 * real'(m + 1) * real'(2 << n));
        if (f <= real'(rq) && f > best_f) begin
          best_f = f;
          code   = (m << 3) | n;
        end
      end
    end
    return code;
  endfunction

  function automatic int spacing(input int code);
    return ((code >> 3) + 1) * (2 << (code & 7));
  endfunction

  task automatic run_search(input logic [31:0] r, input bit intf, input logic [31:0] r2,
                            output int cyc);
    @(negedge clk);
    start_i  = 1'b1;
    req_hz_i = r;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 400) begin
      if (intf && cyc == 50) begin start_i = 1'b1; req_hz_i = r2; end
      else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < 6000);
  endtask

  task automatic search_and_check(input logic [31:0] r, input string tag, input bit measure);
    int cyc, n1, n2, e;
    e = exp_baud(r, int'(baud_o));
    run_search(r, 1'b0, '0, cyc);
    check(cyc == 129, "R7 done latency", cyc, 129);
    check(int'(baud_o) == e, tag, int'(baud_o), e);
    if (measure) begin
      wait_tick(n1);
      check(n1 == spacing(e), "R9 first tick after done", n1, spacing(e));
      wait_tick(n2);
      check(n2 == spacing(e), "R2 tick spacing", n2, spacing(e));
      @(negedge clk);
      check(!tick_o, "R3 tick width", int'(tick_o), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, n1, e, extra;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(baud_o == 7'h44, "R1 reset setting", int'(baud_o), 'h44);
    check(!done_o, "R1 reset done", int'(done_o), 0);
    check(!tick_o, "R1 reset tick", int'(tick_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(baud_o == 7'h44, "R1 setting after reset", int'(baud_o), 'h44);

    // R2 reset setting: 9 * 32 cycles
    wait_tick(n1);
    wait_tick(n1);
    check(n1 == 288, "R2 reset spacing", n1, 288);
    @(negedge clk);
    check(!tick_o, "R3 tick width", int'(tick_o), 0);

    // R6 nothing qualifies from reset
    search_and_check(32'd1000, "R6 no candidate keeps 0x44", 1'b1);

    // R4 fastest setting, two-cycle boundary
    search_and_check(32'd100_000_000, "R4 fastest setting", 1'b1);
    check(baud_o == 7'h00, "R4 smallest code", int'(baud_o), 0);

    // R5 tie at exactly 2.5 MHz
    search_and_check(32'd2_500_000, "R5 tie keeps first", 1'b1);
    check(baud_o == 7'h08, "R5 tie code", int'(baud_o), 'h08);

    // R4 one below the exact rate excludes it
    search_and_check(32'd2_499_999, "R4 just below exact rate", 1'b1);

    // R6 zero request keeps previous value
    e = int'(baud_o);
    search_and_check(32'd0, "R6 zero request", 1'b0);
    check(int'(baud_o) == e, "R6 unchanged value", int'(baud_o), e);

    // R8 start during search ignored
    e = exp_baud(32'd400_000, int'(baud_o));
    run_search(32'd400_000, 1'b1, 32'd10_000, cyc);
    check(cyc == 129, "R8 latency with stray start", cyc, 129);
    check(int'(baud_o) == e, "R8 first request kept", int'(baud_o), e);
    extra = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    check(extra == 0, "R8 no second done", extra, 0);

    // R4 random requests
    for (int k = 0; k < 12; k++) begin
      logic [31:0] r = $urandom_range(6_000_000, 3_000);
      search_and_check(r, "R4 random request", spacing(exp_baud(r, int'(baud_o))) <= 1200);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule